// File: doc/BRIEF.md
# Eight-Channel Converter Serial Command Receiver

This block is the digital front end of an eight-channel voltage-output converter. A host writes 16-bit command words over a three-wire serial port: a serial clock, a data line and a frame/load strobe. Each word carries a 4-bit command field and a channel code of parameterised width (8 or 10 bits). When the strobe rises, the receiver decodes the command. It then loads one channel register, loads all eight at once, changes nothing, or puts the analog section to sleep.

The serial clock and the strobe are not used as clocks. Both pass through synchronisers and edge detectors in the system clock domain, so the system clock must run at least four times faster than the serial clock. The last shift stage is driven out on a serial output, so several receivers can be chained on one port. An active-low clear input empties the shift register and every channel register at once, without waiting for a clock edge.

Top module: `octdac_cmd_rx`

## Requirements
- R1: While the synchronised strobe `ld_n_i` is low, each rising edge of `sck_i` shifts `sdi_i` into a 16-bit shift register, entering at bit 0 and moving toward bit 15, so the first bit sent ends up in bit 15.
- R2: While `ld_n_i` is high, edges on `sck_i` do not change the shift register or `sdo_o`.
- R3: On a rising edge of `ld_n_i`, bits 15..12 of the shift register form the command and the next `CODE_W` bits below them form the code (MSB first). Commands 1 to 8 load channel 0 to 7 respectively, and channel k appears on `chan_code_o[k*CODE_W +: CODE_W]`.
- R4: Command 15 loads the same code into all eight channels in the same cycle.
- R5: Commands 0 and 9 to 13 leave every channel register unchanged.
- R6: Command 14 sets `sleep_o`, ignores the code and leaves every channel register unchanged. The serial port keeps working in sleep.
- R7: While `sleep_o` is set, a load with any command other than 14, including the no-change commands, clears `sleep_o`.
- R8: `sdo_o` presents bit 15 of the shift register, so a bit entered on `sdi_i` appears on `sdo_o` after 16 qualified rising edges of `sck_i`.
- R9: Driving `clr_n_i` low clears the shift register and all channel registers to zero without waiting for a clock edge. `sleep_o` is unaffected.
- R10: After `rst_n` is released, all channel codes are zero, `sleep_o` is 0 and `sdo_o` is 0.
- R11: A frame with fewer or more than 16 serial clock edges is still acted on, using whatever the shift register holds when the strobe rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| clr_n_i | input | 1 | Asynchronous clear of shift and channel registers, active low |
| sck_i | input | 1 | Serial clock, sampled by the system clock |
| sdi_i | input | 1 | Serial data in |
| ld_n_i | input | 1 | Frame strobe: low to shift, rising edge to act |
| sdo_o | output | 1 | Serial data out for chaining |
| chan_code_o | output | NCH*CODE_W | Packed channel codes, channel 0 in the low bits |
| sleep_o | output | 1 | Sleep request for the analog section |

## Verification
The bench toggles the serial clock while the strobe is high and then checks that the chained output still follows the reference bit stream. A design that sampled regardless of the strobe would shift stray ones into later frames. The no-change commands and the sleep command are sent with nonzero codes. A decoder that treated them as loads, or that stayed asleep after a no-change command, would show the wrong codes or a stuck sleep flag. Frames of 12, 20 and 32 edges check that the action uses the current register contents and that the chain output lags by exactly 16 edges. A clear pulse in the middle of a frame while asleep must zero the channels and keep the sleep flag.

// File: rtl/octdac_pkg.sv
package octdac_pkg;
   localparam int CMD_W = 4;
   typedef logic [CMD_W-1:0] cmd_t;

   localparam cmd_t CMD_SLEEP = 4'he;
   localparam cmd_t CMD_ALL   = 4'hf;

   function automatic logic cmd_targets(input cmd_t cmd, input int unsigned ch);
      return (cmd == CMD_ALL) || (int'(cmd) == ch + 1);
   endfunction
endpackage

// File: rtl/octdac_edge_sync.sv
module octdac_edge_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {(STAGES+1){RST_VAL}};
      else        chain <= {chain[STAGES-1:0], async_i};
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/octdac_shifter.sv
module octdac_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_n,
   input  logic              shift_en,
   input  logic              din,
   output logic [WORD_W-1:0] word_o
);
   always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n) word_o <= '0;
      else if (shift_en)    word_o <= {word_o[WORD_W-2:0], din};
   end
endmodule

// File: rtl/octdac_chan_bank.sv
module octdac_chan_bank
   import octdac_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int CODE_W = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_n,
   input  logic                  act,
   input  cmd_t                  cmd,
   input  logic [CODE_W-1:0]     code,
   output logic [NCH*CODE_W-1:0] codes_o,
   output logic                  sleep_o
);
   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic [CODE_W-1:0] val;
      always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
         if (!rst_n || !clr_n)                  val <= '0;
         else if (act && cmd_targets(cmd, k))   val <= code;
      end
      assign codes_o[k*CODE_W +: CODE_W] = val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sleep_o <= 1'b0;
      else if (act) sleep_o <= (cmd == CMD_SLEEP);
   end
endmodule

// File: rtl/octdac_cmd_rx.sv
module octdac_cmd_rx
   import octdac_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int CODE_W      = 10,
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_n_i,
   input  logic                  sck_i,
   input  logic                  sdi_i,
   input  logic                  ld_n_i,
   output logic                  sdo_o,
   output logic [NCH*CODE_W-1:0] chan_code_o,
   output logic                  sleep_o
);
   localparam int CODE_MSB = WORD_W - CMD_W - 1;

   if (CMD_W + CODE_W > WORD_W) begin : g_bad_width
      $fatal(1, "command plus code exceed the word");
   end
   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $fatal(1, "channel count must be 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "at least two synchroniser stages");
   end

   logic sck_lvl, sck_rise, ld_lvl, ld_rise, shift_en;
   logic [WORD_W-1:0] word;

   octdac_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck (
      .clk(clk), .rst_n(rst_n), .async_i(sck_i), .level_o(sck_lvl), .rise_o(sck_rise));
   octdac_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ld (
      .clk(clk), .rst_n(rst_n), .async_i(ld_n_i), .level_o(ld_lvl), .rise_o(ld_rise));

   assign shift_en = sck_rise & ~ld_lvl;

   octdac_shifter #(.WORD_W(WORD_W)) u_sh (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n_i), .shift_en(shift_en),
      .din(sdi_i), .word_o(word));

   assign sdo_o = word[WORD_W-1];

   octdac_chan_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n_i), .act(ld_rise),
      .cmd(word[WORD_W-1 -: CMD_W]), .code(word[CODE_MSB -: CODE_W]),
      .codes_o(chan_code_o), .sleep_o(sleep_o));
endmodule

// File: rtl/octdac_cmd_rx_chk.sv
module octdac_cmd_rx_chk #(
   parameter int NCH    = 8,
   parameter int CODE_W = 10
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  clr_n_i,
   input logic                  shift_en,
   input logic                  ld_rise,
   input logic [3:0]            cmd,
   input logic                  sdo_o,
   input logic [NCH*CODE_W-1:0] chan_code_o,
   input logic                  sleep_o
);
   // R2: the chained output only moves on a qualified serial edge
   a_r2_sdo_quiet: assert property (@(posedge clk) disable iff (!rst_n || !clr_n_i)
      !shift_en |=> $stable(sdo_o));
   // R5: channels only move on a load
   a_r5_codes_hold: assert property (@(posedge clk) disable iff (!rst_n || !clr_n_i)
      !ld_rise |=> $stable(chan_code_o));
   // R6: sleep command sets the flag and keeps the channels
   a_r6_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n || !clr_n_i)
      (ld_rise && cmd == 4'he) |=> (sleep_o && $stable(chan_code_o)));
   // R7: any other load wakes
   a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_rise && cmd != 4'he) |=> !sleep_o);
   // R6: sleep flag moves only on a load
   a_r6_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_rise |=> $stable(sleep_o));
   // R9: clear holds every channel at zero
   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_i |-> (chan_code_o == '0 && !sdo_o));
endmodule

bind octdac_cmd_rx octdac_cmd_rx_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n_i), .shift_en(shift_en),
   .ld_rise(ld_rise), .cmd(word[WORD_W-1 -: 4]), .sdo_o(sdo_o),
   .chan_code_o(chan_code_o), .sleep_o(sleep_o));

// File: tb/tb_octdac_cmd_rx.sv
module tb_octdac_cmd_rx;
   localparam int NCH = 8;
   localparam int CW  = 10;

   logic clk = 0, rst_n = 0, clr_n = 1, sck = 0, sdi = 0, ld_n = 1;
   logic sdo, sleep;
   logic [NCH*CW-1:0] codes;

   int errors = 0, checks = 0;
   logic [15:0]   m_sh = '0;
   logic [CW-1:0] m_ch [NCH];
   logic          m_sleep = 0;

   always #5 clk = ~clk;

   octdac_cmd_rx #(.NCH(NCH), .CODE_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .sck_i(sck), .sdi_i(sdi),
      .ld_n_i(ld_n), .sdo_o(sdo), .chan_code_o(codes), .sleep_o(sleep));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      for (int k = 0; k < NCH; k++)
         check(tag, 32'(codes[k*CW +: CW]), 32'(m_ch[k]));
      check(tag, 32'(sleep), 32'(m_sleep));
      check(tag, 32'(sdo), 32'(m_sh[15]));
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sck_pulse(input logic bitv, input bit model_shift);
      sdi = bitv;
      wait_clk(4);
      sck = 1;
      wait_clk(4);
      sck = 0;
      if (model_shift) m_sh = {m_sh[14:0], bitv};
   endtask

   // sends bits[n-1..0], first bit is bits[n-1]
   task automatic frame(input logic [31:0] bits, input int n, input string tag);
      ld_n = 0;
      wait_clk(4);
      for (int i = n - 1; i >= 0; i--) begin
         sck_pulse(bits[i], 1);
         check({tag, " R8 sdo"}, 32'(sdo), 32'(m_sh[15]));
      end
      wait_clk(4);
      ld_n = 1;
      wait_clk(8);
      begin
         logic [3:0]    c  = m_sh[15:12];
         logic [CW-1:0] cd = m_sh[11 -: CW];
         for (int k = 0; k < NCH; k++)
            if (c == 4'hf || int'(c) == k + 1) m_ch[k] = cd;
         m_sleep = (c == 4'he);
      end
      check_all(tag);
   endtask

   function automatic logic [15:0] word(input logic [3:0] c, input logic [CW-1:0] cd);
      return {c, cd, {(12-CW){1'b0}}};
   endfunction

   initial begin
      for (int k = 0; k < NCH; k++) m_ch[k] = '0;
      wait_clk(3);
      rst_n = 1;
      wait_clk(4);
      check_all("R10 reset");

      for (int k = 0; k < NCH; k++)
         frame(32'(word(4'(k + 1), CW'(37 * k + 5))), 16, "R1 R3 single load");

      // R2: serial clocks with the strobe high are ignored
      for (int i = 0; i < 5; i++) sck_pulse(1'b1, 0);
      wait_clk(4);
      check("R2 idle sck", 32'(sdo), 32'(m_sh[15]));
      frame(32'(word(4'h0, 10'h3ff)), 16, "R2 R5 after idle sck");

      frame(32'(word(4'h9, 10'h155)), 16, "R5 no change 9");
      frame(32'(word(4'hd, 10'h2aa)), 16, "R5 no change 13");
      frame(32'(word(4'hf, 10'h1c3)), 16, "R4 broadcast");
      frame(32'(word(4'h3, 10'h07e)), 16, "R3 reload ch2");

      frame(32'(word(4'he, 10'h3ff)), 16, "R6 sleep");
      frame(32'(word(4'h0, 10'h111)), 16, "R7 wake by no change");
      frame(32'(word(4'he, 10'h000)), 16, "R6 sleep again");
      frame(32'(word(4'h5, 10'h0f0)), 16, "R7 wake by load");

      // R8: two words in one frame, the second one acts
      frame({word(4'h1, 10'h2d2), word(4'h8, 10'h135)}, 32, "R8 chained frame");

      frame(32'hab7, 12, "R11 short frame");
      frame(32'hfc2ab, 20, "R11 long frame");

      // R9: clear mid-frame while asleep
      frame(32'(word(4'he, 10'h0)), 16, "R9 setup sleep");
      ld_n = 0;
      wait_clk(4);
      for (int i = 0; i < 6; i++) sck_pulse(1'b1, 1);
      clr_n = 0;
      #2;
      for (int k = 0; k < NCH; k++) m_ch[k] = '0;
      m_sh = '0;
      check_all("R9 clear async");
      wait_clk(3);
      clr_n = 1;
      wait_clk(2);
      ld_n = 1;
      wait_clk(8);
      m_sleep = 0;
      check_all("R9 R7 after clear");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule